// File: doc/BRIEF.md
# I2C Target with Strap-Configured Address

This block is a target (slave) on a two-wire I2C bus, sitting behind a system clock that oversamples both bus lines. It synchronises SCL and SDA and recognises START, repeated START and STOP conditions. It collects the first byte after every START and compares its upper seven bits with its own address. The address is built from a fixed upper part, set by a parameter, and low bits taken from strap pins. On a match it acknowledges and then takes the role selected by the eighth bit: receiver when that bit is 0, transmitter when it is 1.

As a receiver it hands each byte to the local logic with a single-cycle strobe and acknowledges it. As a transmitter it asks the local logic for each byte with a single-cycle request and shifts the byte out MSB first. It keeps sending while the master acknowledges and lets go of SDA when the master answers NACK. A repeated START with the same address and the opposite direction bit switches the role inside one transfer. SDA is driven open-drain: the block only ever pulls the line low.

Top module: `i2c_addr_target`

## Requirements
- R1: A falling SDA while SCL is high is a START and a rising SDA while SCL is high is a STOP. A START at any point, including inside a byte, restarts address decoding and releases SDA.
- R2: The device address is the fixed part (default binary 1010, parameter `FIXED_PART` bits 6..3) joined with the three strap bits `addr_strap` as bits 2..0. The first seven bits after START, sent MSB first, are compared with it.
- R3: On an address match the block pulls SDA low (`sda_oe`=1) for the whole ninth clock after the address byte, including when the direction bit selects transmit.
- R4: On a mismatch the block gives no acknowledge and ignores every following bit until the next START or STOP: no `rx_valid`, no `tx_req`, and `sda_oe` stays 0.
- R5: With direction bit 0, each following byte is captured MSB first. It appears on `rx_data` with a one-cycle `rx_valid` after its eighth SCL rise and is then acknowledged.
- R6: With direction bit 1, a one-cycle `tx_req` follows each acknowledge that calls for a byte. `tx_data` is sampled in the cycle `tx_req` is high and is sent MSB first, with a 0 bit pulling SDA low.
- R7: As transmitter, a master ACK (SDA low at the ninth rise) leads to another `tx_req`. A master NACK releases SDA, and no further `tx_req` follows until a new START.
- R8: Apart from the release on START or STOP, `sda_oe` changes only while SCL is low.
- R9: In a combined transfer, a repeated START followed by the same address with the direction bit reversed switches the block from receiver to transmitter within the transfer.
- R10: `rx_valid` and `tx_req` are single-cycle pulses. After reset `sda_oe`, `rx_valid` and `tx_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | STRAP_W (3) | Low address bits from strap pins |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |
| rx_data | output | 8 | Last byte received from the master |
| tx_req | output | 1 | One-cycle request for the next byte to send |
| tx_data | input | 8 | Byte to send, sampled while `tx_req` is high |

## Verification
The bench mixes addresses that miss only in a strap bit with addresses that miss only in the fixed part. A design that compared only one part of the address would then acknowledge the wrong target. It also aborts an address byte with STOP and with a repeated START. A design that kept counting bits across a START would misread the next address and acknowledge nothing. A multi-byte read ends in a NACK and a combined write-then-read follows a repeated START. A target that kept driving after the NACK, or that did not reload its direction bit, would corrupt the master's STOP or return write-mode behaviour. SDA changes are also watched while SCL is high, because a late change there would be seen as a false START or STOP.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the strap-addressed I2C target.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    // Byte-engine phases.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX_LOAD,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Bus line conditioner: brings SCL/SDA into the clk domain through a
// configurable synchroniser chain and derives SCL edges and START/STOP.
// Assumes clk runs many times faster than SCL; lines idle high.
module i2c_tgt_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Synchroniser chains plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_s     = scl_pipe[SYNC_STAGES-1];
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
// Byte engine: address compare, acknowledge, receive and transmit phases.
// Samples SDA on SCL rise and changes its drive only after SCL fall.
// Assumes start/stop/edge strobes are single-cycle and already synchronised.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              sda_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              tx_req
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    tgt_state_t        state;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] nxt;
    logic [CNT_W-1:0]  cnt;
    logic              is_read;
    logic              ack_ph;

    // Shift value with the current SDA sample appended.
    always_comb nxt = {sh[BYTE_W-2:0], sda_s};

    // Main sequencer; bus conditions override every phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sh       <= '0;
            cnt      <= '0;
            is_read  <= 1'b0;
            ack_ph   <= 1'b0;
            sda_oe   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            tx_req   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
                ack_ph <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                ack_ph <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: if (scl_rise) begin
                        sh  <= nxt;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            if (nxt[BYTE_W-1:1] == my_addr) begin
                                is_read <= nxt[0];
                                state   <= ST_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_RX: if (scl_rise) begin
                        sh  <= nxt;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            rx_data  <= nxt;
                            rx_valid <= 1'b1;
                            state    <= ST_ACK;
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!ack_ph) begin
                            sda_oe <= 1'b1;
                            ack_ph <= 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                            ack_ph <= 1'b0;
                            if (is_read) begin
                                tx_req <= 1'b1;
                                state  <= ST_TX_LOAD;
                            end else begin
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_TX_LOAD: begin
                        sh     <= tx_data;
                        sda_oe <= ~tx_data[BYTE_W-1];
                        cnt    <= '0;
                        state  <= ST_TX;
                    end
                    ST_TX: if (scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            ack_ph <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            sda_oe <= ~sh[BYTE_W-2];
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            ack_ph <= ~sda_s;
                            if (sda_s) state <= ST_IGNORE;
                        end else if (scl_fall && ack_ph) begin
                            ack_ph <= 1'b0;
                            tx_req <= 1'b1;
                            state  <= ST_TX_LOAD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_addr_target.sv
// Top of the I2C target: forms the address from a fixed parameter part
// and strap pins, conditions the bus lines and runs the byte engine.
// Assumes straps are static while the bus is busy.
module i2c_addr_target
    import i2c_tgt_pkg::*;
#(
    parameter int         STRAP_W     = 3,
    parameter logic [6:0] FIXED_PART  = 7'b1010000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] addr_strap,
    output logic               rx_valid,
    output logic [BYTE_W-1:0]  rx_data,
    output logic               tx_req,
    input  logic [BYTE_W-1:0]  tx_data
);
    localparam int FIXED_W = ADDR_W - STRAP_W;

    logic              scl_sync;
    logic              sda_sync;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_seen;
    logic              stop_seen;
    logic [ADDR_W-1:0] my_addr;

    // Address assembly: fixed upper bits, strapped lower bits.
    always_comb my_addr = {FIXED_PART[ADDR_W-1 -: FIXED_W], addr_strap};

    i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_sync),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_seen),
        .stop_det  (stop_seen)
    );

    i2c_tgt_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_sync),
        .start_det (start_seen),
        .stop_det  (stop_seen),
        .my_addr   (my_addr),
        .tx_data   (tx_data),
        .sda_oe    (sda_oe),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_req    (tx_req)
    );
endmodule

// File: rtl/i2c_addr_target_chk.sv
// Protocol checker for the I2C target, bound to the top module.
module i2c_addr_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic rx_valid,
    input logic tx_req
);
    assert_sda_quiet_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    assert_start_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_rx_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_tx_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    assert_role_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && tx_req));
endmodule

bind i2c_addr_target i2c_addr_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_sync),
    .start_det (start_seen),
    .stop_det  (stop_seen),
    .sda_oe    (sda_oe),
    .rx_valid  (rx_valid),
    .tx_req    (tx_req)
);

// File: tb/i2c_addr_target_tb.sv
// Bench: open-drain bus model with a bit-banged master; vector table
// first, then directed corner cases.
module i2c_addr_target_tb;
    localparam int H = 10;  // clk cycles per bus phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [2:0] strap = 3'b000;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       tx_req;
    logic [7:0] tx_data;
    logic [7:0] tx_q [4];

    int n_chk = 0, n_bad = 0;
    int rx_cnt = 0, tx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    int pulse_err = 0, hi_err = 0;
    logic prev_rx = 1'b0, prev_tx = 1'b0, prev_scl = 1'b1, prev_oe = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign tx_data = tx_q[tx_cnt[1:0]];

    i2c_addr_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .addr_strap (strap),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .tx_req     (tx_req),
        .tx_data    (tx_data)
    );

    // Advance the transmit queue together with the design's load edge.
    always @(posedge clk) if (tx_req) tx_cnt <= tx_cnt + 1;

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
        if ((rx_valid && prev_rx) || (tx_req && prev_tx)) pulse_err <= pulse_err + 1;
        if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe) && sda_oe) hi_err <= hi_err + 1;
        prev_rx  <= rx_valid;
        prev_tx  <= tx_req;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H / 2);
        ack = (sda_bus == 1'b0);
        wait_clk(H / 2);
        scl_m = 1'b0; wait_clk(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(H);
            scl_m = 1'b1; wait_clk(H / 2);
            b[i] = sda_bus;
            wait_clk(H / 2);
            scl_m = 1'b0;
        end
        wait_clk(2);
        sda_m = give_ack ? 1'b0 : 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        scl_m = 1'b0; wait_clk(2);
    endtask

    // Vector: strap[19:17] addr[16:10] rw[9] data[8:1] expect_ack[0]
    localparam logic [19:0] VEC [7] = '{
        {3'b001, 7'h51, 1'b0, 8'hA5, 1'b1},
        {3'b001, 7'h52, 1'b0, 8'h3C, 1'b0},
        {3'b110, 7'h56, 1'b1, 8'h9B, 1'b1},
        {3'b110, 7'h57, 1'b0, 8'h00, 1'b0},
        {3'b000, 7'h50, 1'b1, 8'h01, 1'b1},
        {3'b111, 7'h57, 1'b0, 8'hFE, 1'b1},
        {3'b011, 7'h13, 1'b0, 8'h77, 1'b0}
    };

    initial begin
        logic       ack;
        logic [7:0] got;
        int         rx0, tx0;

        wait_clk(4);
        check(sda_oe == 1'b0,   "R10 reset sda_oe",   sda_oe,   0);
        check(rx_valid == 1'b0, "R10 reset rx_valid", rx_valid, 0);
        check(tx_req == 1'b0,   "R10 reset tx_req",   tx_req,   0);
        rst_n = 1'b1;
        wait_clk(4);

        // Table walk: address compare, direction, single byte each way.
        for (int i = 0; i < 7; i++) begin
            logic [19:0] v;
            v = VEC[i];
            strap = v[19:17];
            wait_clk(4);
            rx0 = rx_cnt; tx0 = tx_cnt;
            tx_q[tx_cnt[1:0]] = v[8:1];
            bus_start();
            send_byte({v[16:10], v[9]}, ack);
            check(ack == v[0], "R2/R3 address ack", ack, v[0]);
            if (!v[9]) begin
                send_byte(v[8:1], ack);
                if (v[0]) begin
                    check(ack && rx_last == v[8:1] && rx_cnt == rx0 + 1,
                          "R5 write byte", rx_last, v[8:1]);
                end else begin
                    check(!ack && rx_cnt == rx0, "R4 unaddressed write ignored",
                          rx_cnt - rx0, 0);
                end
            end else begin
                recv_byte(1'b0, got);
                check(got == v[8:1] && tx_cnt == tx0 + 1, "R6 read byte", got, v[8:1]);
            end
            bus_stop();
        end

        // Multi-byte write.
        strap = 3'b001; wait_clk(4);
        rx0 = rx_cnt;
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(8'h11, ack); check(ack && rx_last == 8'h11, "R5 burst byte 1", rx_last, 8'h11);
        send_byte(8'h22, ack); check(ack && rx_last == 8'h22, "R5 burst byte 2", rx_last, 8'h22);
        send_byte(8'h33, ack); check(ack && rx_last == 8'h33, "R5 burst byte 3", rx_last, 8'h33);
        check(rx_cnt == rx0 + 3, "R5 burst count", rx_cnt - rx0, 3);
        bus_stop();

        // Two-byte read: ACK then NACK.
        tx0 = tx_cnt;
        tx_q[tx_cnt[1:0]] = 8'hC3;
        tx_q[(tx_cnt + 1) & 3] = 8'h5A;
        bus_start();
        send_byte(8'hA3, ack);
        check(ack, "R3 ack on read address", ack, 1);
        recv_byte(1'b1, got); check(got == 8'hC3, "R7 read byte after ack", got, 8'hC3);
        recv_byte(1'b0, got); check(got == 8'h5A, "R6 second read byte", got, 8'h5A);
        wait_clk(3 * H);
        check(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
        check(tx_cnt == tx0 + 2, "R7 no request after nack", tx_cnt - tx0, 2);
        // Extra clocks after NACK must not pull SDA or request data.
        put_bit(1'b1); put_bit(1'b1);
        check(sda_oe == 1'b0 && tx_cnt == tx0 + 2, "R7 idle after nack", tx_cnt - tx0, 2);
        bus_stop();

        // Combined write then read through repeated START.
        rx0 = rx_cnt;
        tx_q[tx_cnt[1:0]] = 8'h6E;
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(8'h44, ack);
        check(ack && rx_last == 8'h44, "R9 write phase", rx_last, 8'h44);
        bus_start();
        send_byte(8'hA3, ack);
        check(ack, "R9 ack after repeated start", ack, 1);
        recv_byte(1'b0, got);
        check(got == 8'h6E && rx_cnt == rx0 + 1, "R9 read phase", got, 8'h6E);
        bus_stop();

        // STOP inside an address byte, then a clean write.
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        scl_m = 1'b0; wait_clk(H);
        bus_stop();
        bus_start();
        send_byte(8'hA2, ack);
        check(ack, "R1 decode after aborted address", ack, 1);
        bus_stop();

        // Unaddressed, then repeated START with own address mid-byte.
        bus_start();
        send_byte(8'hB2, ack);
        check(!ack && sda_oe == 1'b0, "R4 foreign address", ack, 0);
        put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte(8'hA2, ack);
        send_byte(8'h9D, ack);
        check(ack && rx_last == 8'h9D, "R1 restart mid-byte", rx_last, 8'h9D);
        bus_stop();

        wait_clk(10);
        check(pulse_err == 0, "R10 single-cycle strobes", pulse_err, 0);
        check(hi_err == 0, "R8 drive only while SCL low", hi_err, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule